// File: doc/BRIEF.md
# Cell Framer with Command-Octet Insertion

This block sits between a transmit cell buffer and the line encoder of a cell-based physical layer. It reads cells of a fixed length, 53 octets by default, from the buffer. Before each cell it emits one start-of-cell command octet. That command comes in two forms. One tells the transmit scrambler and the far-end descrambler to return to their initial state. The other leaves both running. A configuration input picks the form for each new cell. The very first cell after reset always uses the resetting form.

The block also watches an 8 kHz timing reference. A rising edge on it queues a timing-marker command octet. The marker outpranks everything else on the line. If a cell is in flight, the marker is slipped in at the next octet boundary and the cell resumes right after it. That is the only break ever allowed inside a cell. When the buffer holds no complete cell and no marker is due, the output valid flag stays low.

Each command octet carries an escape symbol in its upper nibble (`4'hF`) and a code in its lower nibble. The codes are `F` (start-of-cell with reset, octet `8'hFF`), `4` (start-of-cell without reset, octet `8'hF4`) and `8` (timing marker, octet `8'hF8`). The buffer behaves as a show-ahead FIFO. `cell_avail` means at least one whole cell is waiting. `src_octet` is the head octet, and `src_take` consumes that octet in the same cycle.

Top module: `cell_cmd_framer`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_is_cmd` and `out_scr_reset` are all 0 after the next rising clock edge.
- R2: Every cell goes out as exactly one start-of-cell command octet followed by `CELL_OCTETS` data octets. No start-of-cell command appears while a cell is incomplete.
- R3: The first start-of-cell command after reset is `8'hFF` with `out_scr_reset` high, whatever the value of `cfg_scr_reset`.
- R4: Every later start-of-cell command is `8'hFF` with `out_scr_reset` high when `cfg_scr_reset` was 1 at the deciding clock edge. Otherwise it is `8'hF4` with `out_scr_reset` low.
- R5: A rising edge of `sync_in` that is first sampled at clock edge n produces exactly one timing-marker octet `8'hF8` on the output after edge n+2. The marker has `out_is_cmd` high and `out_scr_reset` low. This holds in the middle of a cell, at a cell boundary and while idle.
- R6: Data octets come out with `out_is_cmd` low, in buffer order, with one `src_take` per data octet. Inside a cell the only cycle without a data octet is a timing-marker cycle.
- R7: When no cell is in progress, no complete cell is available and no marker is due, `out_valid` is low on the next cycle.
- R8: Holding `sync_in` high for several cycles yields a single timing marker. Only a rising edge creates one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_scr_reset | input | 1 | 1: next start-of-cell uses the scrambler-reset form |
| sync_in | input | 1 | 8 kHz timing reference, level input |
| cell_avail | input | 1 | At least one whole cell waits in the buffer |
| src_octet | input | 8 | Head octet of the buffer (show-ahead) |
| src_take | output | 1 | Consume the head octet this cycle |
| out_valid | output | 1 | An octet is presented this cycle |
| out_octet | output | 8 | Data or command octet |
| out_is_cmd | output | 1 | The octet is a command octet |
| out_scr_reset | output | 1 | Scrambler-reset strobe, high with `8'hFF` only |

## Verification
The bench builds the framer with the default cell length of 53. It runs a stream of 120 back-to-back cells and drives timing pulses 56 cycles apart. Each pulse then lands one slot later within the 54-octet cell frame than the one before, so the 111 pulses cover every insertion point: before the start-of-cell command, after it, at each data octet and right at the cell boundary. Short runs of one and two cells exercise the forced first reset form and both settings of the configuration input. Idle phases cover the silent output, a marker sent with no cell present, and a level held high.

// File: rtl/framer_pkg.sv
// Shared encodings for the cell framer: command octets and the emit selector.
package framer_pkg;

    localparam logic [3:0] ESC_NIB      = 4'hF;
    localparam logic [7:0] CMD_SOC_RST  = {ESC_NIB, 4'hF};
    localparam logic [7:0] CMD_SOC_RUN  = {ESC_NIB, 4'h4};
    localparam logic [7:0] CMD_MARK     = {ESC_NIB, 4'h8};

    typedef enum logic [2:0] {
        EM_NONE,
        EM_MARK,
        EM_SOC_RST,
        EM_SOC_RUN,
        EM_DATA
    } emit_t;

endpackage

// File: rtl/framer_tick_capture.sv
// Samples the timing reference, detects its rising edge and holds a marker
// request until the framer serves it.
// Assumes: sync_in is already synchronous to clk.
module framer_tick_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic served,
    output logic pending
);

    logic s_q;
    logic s_prev;
    logic rise;

    // Edge detector on the sampled reference.
    assign rise = s_q & ~s_prev;

    // Sample the reference and remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_q    <= sync_in;
            s_prev <= s_q;
        end
    end

    // Set on an edge, clear when served; a new edge wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= rise | (pending & ~served);
    end

endmodule

// File: rtl/framer_cell_count.sv
// Counts the data octets still owed to the cell in progress.
// Assumes: start and advance are never high together.
module framer_cell_count #(
    parameter int CELL_OCTETS = 53,
    localparam int CNT_W = $clog2(CELL_OCTETS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic advance,
    output logic in_cell
);

    logic [CNT_W-1:0] left;

    // A cell is in progress while octets remain.
    assign in_cell = (left != '0);

    // Load on a start-of-cell, step down on each data octet.
    always_ff @(posedge clk) begin
        if (!rst_n)       left <= '0;
        else if (start)   left <= CNT_W'(CELL_OCTETS);
        else if (advance) left <= left - 1'b1;
    end

endmodule

// File: rtl/framer_out_reg.sv
// Output register: turns the emit choice and the head octet into the
// registered downstream octet, command flag and scrambler-reset strobe.
module framer_out_reg
    import framer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  emit_t      emit,
    input  logic [7:0] data,
    output logic       out_valid,
    output logic [7:0] out_octet,
    output logic       out_is_cmd,
    output logic       out_scr_reset
);

    logic [7:0] octet_d;

    // Select the octet for the chosen emit kind.
    always_comb begin
        case (emit)
            EM_MARK:    octet_d = CMD_MARK;
            EM_SOC_RST: octet_d = CMD_SOC_RST;
            EM_SOC_RUN: octet_d = CMD_SOC_RUN;
            EM_DATA:    octet_d = data;
            default:    octet_d = 8'h00;
        endcase
    end

    // Register everything presented downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_octet     <= 8'h00;
            out_is_cmd    <= 1'b0;
            out_scr_reset <= 1'b0;
        end else begin
            out_valid     <= (emit != EM_NONE);
            out_octet     <= octet_d;
            out_is_cmd    <= (emit == EM_MARK) || (emit == EM_SOC_RST) ||
                             (emit == EM_SOC_RUN);
            out_scr_reset <= (emit == EM_SOC_RST);
        end
    end

endmodule

// File: rtl/cell_cmd_framer.sv
// Cell framer: puts a start-of-cell command before each cell, choosing the
// scrambler-reset form or the running form, and slips a timing marker in at
// the next octet boundary after each rising edge of the timing reference.
// Assumes: the source is show-ahead, and cell_avail is high only when a whole
// cell is buffered.
module cell_cmd_framer
    import framer_pkg::*;
#(
    parameter int CELL_OCTETS = 53
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_scr_reset,
    input  logic       sync_in,
    input  logic       cell_avail,
    input  logic [7:0] src_octet,
    output logic       src_take,
    output logic       out_valid,
    output logic [7:0] out_octet,
    output logic       out_is_cmd,
    output logic       out_scr_reset
);

    emit_t emit;
    logic  tick_pending;
    logic  in_cell;
    logic  force_rst;
    logic  soc_now;

    framer_tick_capture u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .served  (emit == EM_MARK),
        .pending (tick_pending)
    );

    framer_cell_count #(.CELL_OCTETS(CELL_OCTETS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (soc_now),
        .advance (src_take),
        .in_cell (in_cell)
    );

    // Priority: marker, then cell body, then a new start-of-cell.
    always_comb begin
        if (tick_pending)                  emit = EM_MARK;
        else if (in_cell)                  emit = EM_DATA;
        else if (cell_avail)
            emit = (force_rst || cfg_scr_reset) ? EM_SOC_RST : EM_SOC_RUN;
        else                               emit = EM_NONE;
    end

    assign soc_now  = (emit == EM_SOC_RST) || (emit == EM_SOC_RUN);
    assign src_take = (emit == EM_DATA);

    // The first start-of-cell after reset must reset the scramblers.
    always_ff @(posedge clk) begin
        if (!rst_n)       force_rst <= 1'b1;
        else if (soc_now) force_rst <= 1'b0;
    end

    framer_out_reg u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .emit          (emit),
        .data          (src_octet),
        .out_valid     (out_valid),
        .out_octet     (out_octet),
        .out_is_cmd    (out_is_cmd),
        .out_scr_reset (out_scr_reset)
    );

endmodule

// File: rtl/cell_cmd_framer_chk.sv
// Protocol checker for the cell framer, bound to the top module.
module cell_cmd_framer_chk #(
    parameter int CELL_OCTETS = 53
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cell_avail,
    input logic       src_take,
    input logic       out_valid,
    input logic [7:0] out_octet,
    input logic       out_is_cmd,
    input logic       out_scr_reset,
    input logic       pending,
    input logic       in_cell
);
    import framer_pkg::*;

    int   dcount;
    logic seen_soc;
    logic is_data;
    logic is_soc;

    assign is_data = out_valid && !out_is_cmd;
    assign is_soc  = out_valid && out_is_cmd && (out_octet != CMD_MARK);

    // Independent count of data octets since the last start-of-cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcount   <= 0;
            seen_soc <= 1'b0;
        end else if (is_soc) begin
            dcount   <= 0;
            seen_soc <= 1'b1;
        end else if (is_data) begin
            dcount   <= dcount + 1;
        end
    end

    // R5
    marker_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> (out_valid && out_is_cmd && out_octet == CMD_MARK && !out_scr_reset));

    // R4
    scr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_scr_reset |-> (out_valid && out_is_cmd && out_octet == CMD_SOC_RST));

    // R6
    data_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_data |-> $past(src_take));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !in_cell && !cell_avail) |=> !out_valid);

    // R2
    cell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_soc |-> (!seen_soc || dcount == CELL_OCTETS));

    // R2
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_data |-> (seen_soc && dcount < CELL_OCTETS));

endmodule

bind cell_cmd_framer cell_cmd_framer_chk #(.CELL_OCTETS(CELL_OCTETS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cell_avail    (cell_avail),
    .src_take      (src_take),
    .out_valid     (out_valid),
    .out_octet     (out_octet),
    .out_is_cmd    (out_is_cmd),
    .out_scr_reset (out_scr_reset),
    .pending       (tick_pending),
    .in_cell       (in_cell)
);

// File: tb/cell_cmd_framer_tb.sv
module cell_cmd_framer_tb;

    localparam int CELL = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_scr_reset = 1'b0;
    logic       sync_in = 1'b0;
    logic       cell_avail;
    logic [7:0] src_octet;
    logic       src_take;
    logic       out_valid;
    logic [7:0] out_octet;
    logic       out_is_cmd;
    logic       out_scr_reset;

    int supplied = 0;
    int taken    = 0;
    int cyc      = 0;
    logic cfg_q  = 1'b0;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;

    // monitor state
    int   pos = CELL;
    int   exp_seq = 0;
    logic first_seen = 1'b0;
    int   mark_count = 0;
    int   last_mark_cyc = -1;
    int   soc_count = 0;

    always #2.5 clk = ~clk;

    assign cell_avail = (supplied - taken) >= CELL;
    assign src_octet  = taken[7:0];

    cell_cmd_framer #(.CELL_OCTETS(CELL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_scr_reset(cfg_scr_reset),
        .sync_in(sync_in), .cell_avail(cell_avail), .src_octet(src_octet),
        .src_take(src_take), .out_valid(out_valid), .out_octet(out_octet),
        .out_is_cmd(out_is_cmd), .out_scr_reset(out_scr_reset)
    );

    // Buffer model: consumes an octet per src_take, tracks cycle count.
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        cfg_q <= cfg_scr_reset;
        if (rst_n && src_take) taken <= taken + 1;
    end

    task automatic mchk(input logic ok, input string req, input int act, input int exp);
        mon_checks++;
        if (!ok) begin
            mon_errors++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Stream monitor: parses every output octet against the requirements.
    always @(negedge clk) begin
        if (!rst_n) begin
            pos = CELL; first_seen = 1'b0;
        end else if (out_valid && out_is_cmd && out_octet == 8'hF8) begin
            mark_count++;
            last_mark_cyc = cyc;
            mchk(!out_scr_reset, "R5", out_scr_reset, 0);
        end else if (out_valid && out_is_cmd) begin
            mchk(pos == CELL, "R2", pos, CELL);
            if (!first_seen)
                mchk(out_octet == 8'hFF, "R3", out_octet, 8'hFF);
            else
                mchk(out_octet == (cfg_q ? 8'hFF : 8'hF4), "R4", out_octet,
                     cfg_q ? 8'hFF : 8'hF4);
            mchk(out_scr_reset == (out_octet == 8'hFF), "R4", out_scr_reset,
                 out_octet == 8'hFF);
            pos = 0; first_seen = 1'b1; soc_count++;
        end else if (out_valid) begin
            mchk(pos < CELL, "R2", pos, CELL - 1);
            mchk(out_octet == exp_seq[7:0], "R6", out_octet, exp_seq[7:0]);
            pos++; exp_seq++;
        end else begin
            if (pos < CELL) mchk(1'b0, "R6", pos, CELL);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic pulse_sync(input int hold, input string req);
        int n, c0;
        @(negedge clk);
        n  = cyc + 1;
        c0 = mark_count;
        sync_in = 1'b1;
        repeat (hold) @(negedge clk);
        sync_in = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk(mark_count == c0 + 1, req, mark_count - c0, 1);
        chk(last_mark_cyc == n + 2, "R5", last_mark_cyc, n + 2);
    endtask

    task automatic drain();
        while (taken != supplied || pos != CELL) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!out_valid, "R7", out_valid, 0);
        end
    endtask

    initial begin
        int s0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_is_cmd && !out_scr_reset, "R1",
            {out_valid, out_is_cmd, out_scr_reset}, 0);
        rst_n = 1'b1;
        idle_check(8);

        // R3, R4: first cell forced to reset form, second follows cfg=0
        cfg_scr_reset = 1'b0;
        s0 = soc_count;
        supplied = supplied + 2 * CELL;
        drain();
        chk(soc_count == s0 + 2, "R2", soc_count - s0, 2);
        idle_check(5);

        // R4: cfg=1 selects the reset form
        cfg_scr_reset = 1'b1;
        supplied = supplied + CELL;
        drain();

        // R5 while idle, R8 level held high
        pulse_sync(1, "R5");
        idle_check(3);
        pulse_sync(6, "R8");
        idle_check(3);

        // R5, R6: marker swept over every slot of a streaming cell
        cfg_scr_reset = 1'b0;
        s0 = soc_count;
        supplied = supplied + 120 * CELL;
        for (int p = 0; p < 111; p++) begin
            pulse_sync(1, "R5");
            repeat (50) @(negedge clk);
        end
        drain();
        chk(soc_count == s0 + 120, "R2", soc_count - s0, 120);
        chk(exp_seq == supplied, "R6", exp_seq, supplied);
        idle_check(5);

        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end

endmodule